// File: doc/BRIEF.md
# Status Flag Register and Branch Condition Unit

This block keeps the six arithmetic status flags of a 32-bit processor and answers branch-condition queries against them. The execution unit computes a fresh flag vector and presents it with an update strobe; a carry-write select chooses between two update modes. In the full mode all six flags are replaced. In the carry-preserving mode, used by increment, every flag except carry is replaced. A compare is handled by the execution unit as a subtraction whose result is discarded, so it arrives here as an ordinary full update.

A combinational query port takes a 3-bit base-condition selector and a polarity bit. It reports whether a conditional branch is taken, judged against the flags currently held in the register. The stored flag vector is also driven out directly.

Top module: `flagCondUnit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears every stored flag to 0. Reset takes priority over a simultaneous update.
- R2: When `updValid` and `updCarry` are both high at a rising edge, all six flags take the values on `updFlags` after that edge.
- R3: When `updValid` is high and `updCarry` is low at a rising edge, OF, SF, ZF, AF and PF take their values from `updFlags`, and CF keeps its previous value.
- R4: When `updValid` is low at a rising edge, no flag changes, whatever `updFlags` and `updCarry` hold.
- R5: The base condition picked by `qSel` is: 0 = OF, 1 = CF, 2 = ZF, 3 = CF or ZF, 4 = SF, 5 = PF, 6 = SF differs from OF, 7 = ZF or (SF differs from OF).
- R6: `qTaken` is 1 exactly when the selected base condition equals `qPol`, so the two polarities always give opposite answers for the same selector.
- R7: `qTaken` is computed from the registered flags only. An update presented in a cycle does not affect the answer until after the edge that stores it.
- R8: Flag bit positions in both `updFlags` and `flagsOut` are: bit 0 CF, bit 1 PF, bit 2 AF, bit 3 ZF, bit 4 SF, bit 5 OF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| updValid | input | 1 | Flag update strobe |
| updCarry | input | 1 | 1: write carry too; 0: keep carry |
| updFlags | input | 6 | New flag vector (layout per R8) |
| qSel | input | 3 | Base condition selector |
| qPol | input | 1 | Polarity the base condition is compared with |
| qTaken | output | 1 | Branch taken |
| flagsOut | output | 6 | Stored flag vector |

## Verification
Every stored flag appears directly on `flagsOut`, so a wrong bit shows at the ports on the first falling edge after the edge that stored it. A write-enable fault in the carry-preserving mode shows only when the incoming carry differs from the stored one, and the random mix of modes is built to produce that case often. A selector-decode fault stays hidden until a flag state that separates the two conditions is queried with the faulty selector. The exhaustive sweep of 64 flag states by 16 queries reaches every such case within about a thousand cycles.

// File: rtl/flagPkg.sv
package flagPkg;
  localparam int NUM_FLAGS = 6;
  localparam int SEL_W     = 3;

  localparam int CF_POS = 0;
  localparam int PF_POS = 1;
  localparam int AF_POS = 2;
  localparam int ZF_POS = 3;
  localparam int SF_POS = 4;
  localparam int OF_POS = 5;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } flag_t;

  typedef struct packed {
    logic writeMain;
    logic writeCarry;
  } flagStrobe_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_OVF   = 3'd0,
    SEL_BELOW = 3'd1,
    SEL_ZERO  = 3'd2,
    SEL_BEQ   = 3'd3,
    SEL_SIGN  = 3'd4,
    SEL_PAR   = 3'd5,
    SEL_LESS  = 3'd6,
    SEL_LEQ   = 3'd7
  } condSel_e;
endpackage

// File: rtl/flagCtrl.sv
module flagCtrl
  import flagPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        updValid,
  input  logic        updCarry,
  output flagStrobe_t strobes
);
  always_comb begin
    strobes.writeMain  = updValid;
    strobes.writeCarry = updValid & updCarry;
  end

  // R3: the carry strobe never fires without the main strobe
  a_r3_carry_needs_main: assert property (@(posedge clk) disable iff (rst)
    strobes.writeCarry |-> strobes.writeMain);
endmodule

// File: rtl/flagStore.sv
module flagStore
  import flagPkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  flagStrobe_t          strobes,
  input  logic [NUM_FLAGS-1:0] newFlags,
  output flag_t                flagQ
);
  logic [NUM_FLAGS-1:0] flagBits;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    localparam bit IS_CARRY = (i == CF_POS);
    logic bitEn;
    assign bitEn = IS_CARRY ? strobes.writeCarry : strobes.writeMain;
    always_ff @(posedge clk) begin
      if (rst)        flagBits[i] <= 1'b0;
      else if (bitEn) flagBits[i] <= newFlags[i];
    end
  end

  assign flagQ = flag_t'(flagBits);

  // R4: no strobe, no change
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.writeMain |=> $stable(flagQ));
  // R3: carry-preserving mode keeps CF
  a_r3_carry_kept: assert property (@(posedge clk) disable iff (rst)
    (strobes.writeMain && !strobes.writeCarry) |=> (flagQ.cry == $past(flagQ.cry)));
  // R3: carry-preserving mode still writes the other five flags
  a_r3_others_written: assert property (@(posedge clk) disable iff (rst)
    (strobes.writeMain && !strobes.writeCarry) |=>
      (flagBits[NUM_FLAGS-1:1] == $past(newFlags[NUM_FLAGS-1:1])));
  // R2: full mode writes everything
  a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
    (strobes.writeMain && strobes.writeCarry) |=> (flagBits == $past(newFlags)));
endmodule

// File: rtl/condEval.sv
module condEval
  import flagPkg::*;
(
  input  flag_t            flagQ,
  input  logic [SEL_W-1:0] qSel,
  input  logic             qPol,
  output logic             qTaken
);
  logic baseCond;
  logic lessBit;

  always_comb begin
    lessBit = flagQ.sgn ^ flagQ.ovf;
    unique case (condSel_e'(qSel))
      SEL_OVF:   baseCond = flagQ.ovf;
      SEL_BELOW: baseCond = flagQ.cry;
      SEL_ZERO:  baseCond = flagQ.zer;
      SEL_BEQ:   baseCond = flagQ.cry | flagQ.zer;
      SEL_SIGN:  baseCond = flagQ.sgn;
      SEL_PAR:   baseCond = flagQ.par;
      SEL_LESS:  baseCond = lessBit;
      SEL_LEQ:   baseCond = flagQ.zer | lessBit;
      default:   baseCond = 1'b0;
    endcase
    qTaken = ~(baseCond ^ qPol);
  end
endmodule

// File: rtl/flagCondUnit.sv
module flagCondUnit
  import flagPkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 updValid,
  input  logic                 updCarry,
  input  logic [NUM_FLAGS-1:0] updFlags,
  input  logic [SEL_W-1:0]     qSel,
  input  logic                 qPol,
  output logic                 qTaken,
  output logic [NUM_FLAGS-1:0] flagsOut
);
  flagStrobe_t strobes;
  flag_t       flagQ;

  flagCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .updValid (updValid),
    .updCarry (updCarry),
    .strobes  (strobes)
  );

  flagStore u_store (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .newFlags (updFlags),
    .flagQ    (flagQ)
  );

  condEval u_eval (
    .flagQ  (flagQ),
    .qSel   (qSel),
    .qPol   (qPol),
    .qTaken (qTaken)
  );

  assign flagsOut = flagQ;

  // R5: zero selector with polarity 1 follows the stored ZF bit
  a_r5_zero_query: assert property (@(posedge clk) disable iff (rst)
    (qSel == 3'd2 && qPol) |-> (qTaken == flagsOut[ZF_POS]));
  // R5: below selector with polarity 0 is the inverse of stored CF
  a_r5_below_query: assert property (@(posedge clk) disable iff (rst)
    (qSel == 3'd1 && !qPol) |-> (qTaken != flagsOut[CF_POS]));
  // R6: a less-or-equal query with polarity 1 is taken whenever ZF is stored set
  a_r6_leq_zero: assert property (@(posedge clk) disable iff (rst)
    (qSel == 3'd7 && qPol && flagsOut[ZF_POS]) |-> qTaken);
endmodule

// File: tb/flagCondUnit_bench.sv
module flagCondUnit_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       updValid;
  logic       updCarry;
  logic [5:0] updFlags;
  logic [2:0] qSel;
  logic       qPol;
  logic       qTaken;
  logic [5:0] flagsOut;

  int compared   = 0;
  int mismatched = 0;
  int model;

  always #10 clk = ~clk;

  flagCondUnit u_flagCondUnit (
    .clk(clk), .rst(rst), .updValid(updValid), .updCarry(updCarry),
    .updFlags(updFlags), .qSel(qSel), .qPol(qPol),
    .qTaken(qTaken), .flagsOut(flagsOut)
  );

  function automatic int refTaken(int f, int sel, int pol);
    int c, p, a, z, s, o, base;
    c = (f >> 0) & 1; p = (f >> 1) & 1; a = (f >> 2) & 1;
    z = (f >> 3) & 1; s = (f >> 4) & 1; o = (f >> 5) & 1;
    case (sel)
      0: base = o;
      1: base = c;
      2: base = z;
      3: base = (c != 0 || z != 0) ? 1 : 0;
      4: base = s;
      5: base = p;
      6: base = (s != o) ? 1 : 0;
      default: base = (z != 0 || s != o) ? 1 : 0;
    endcase
    return (base == pol) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive inputs (after a negedge), update model for the coming edge
  task automatic drive(bit r, bit v, bit cy, int fl, int sel, bit pol);
    int preModel;
    preModel = model;
    rst = r; updValid = v; updCarry = cy; updFlags = fl[5:0];
    qSel = sel[2:0]; qPol = pol;
    #1;
    // R7: an update not yet clocked has no effect on the answer
    check("R7", int'(qTaken), refTaken(preModel, sel, int'(pol)));
    if (r) model = 0;
    else if (v && cy) model = fl & 63;
    else if (v) model = (fl & 62) | (preModel & 1);
  endtask

  task automatic stepCheck(string req);
    @(negedge clk);
    check(req, int'(flagsOut), model);
    check("R5", int'(qTaken), refTaken(model, int'(qSel), int'(qPol)));
  endtask

  initial begin
    #(20ns * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    model = 0;
    rst = 1'b1; updValid = 1'b1; updCarry = 1'b1; updFlags = 6'h3f;
    qSel = 3'd0; qPol = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1", int'(flagsOut), 0);

    // R8: only ZF (bit 3) set
    drive(0, 1, 1, 8, 2, 1);
    stepCheck("R8");
    check("R8", int'(flagsOut), 8);
    check("R8", int'(qTaken), 1);

    // exhaustive: every flag state, every query
    for (int f = 0; f < 64; f++) begin
      drive(0, 1, 1, f, 0, 1);
      stepCheck("R2");
      for (int s = 0; s < 8; s++) begin
        int t1, t0;
        drive(0, 0, 1, 63 - f, s, 1);
        stepCheck("R4");
        t1 = int'(qTaken);
        drive(0, 0, 0, 63 - f, s, 0);
        stepCheck("R4");
        t0 = int'(qTaken);
        // R6: opposite polarities give opposite answers
        check("R6", t1 ^ t0, 1);
      end
    end

    // carry-preserving mode with differing incoming carry
    drive(0, 1, 1, 1, 1, 1);
    stepCheck("R2");
    drive(0, 1, 0, 62, 1, 1);
    stepCheck("R3");
    check("R3", int'(flagsOut), 63);
    drive(0, 1, 1, 0, 1, 1);
    stepCheck("R2");
    drive(0, 1, 0, 1, 1, 1);
    stepCheck("R3");
    check("R3", int'(flagsOut), 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int m;
      string tag;
      m = $urandom_range(0, 9);
      if (m == 0) tag = "R4";
      else if (m < 5) tag = "R3";
      else tag = "R2";
      drive(0, m != 0, m >= 5, $urandom_range(0, 63), $urandom_range(0, 7), $urandom_range(0, 1));
      stepCheck(tag);
    end

    // R1: reset wins over a simultaneous update
    drive(0, 1, 1, 63, 0, 1);
    stepCheck("R2");
    drive(1, 1, 1, 42, 0, 1);
    stepCheck("R1");
    check("R1", int'(flagsOut), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule